// File: doc/BRIEF.md
# Dual-Port Address-Contention Busy Arbiter

This block sits beside a two-port memory and watches both ports on a shared clock. Each port offers an active-low enable, an active-low write strobe and an address. When both ports are enabled at the same address, the block names one port the owner of that location. It pulls the other port's active-low busy flag down and masks that port's write strobe before the strobe reaches the array.

The owner is the port that was already sitting on the address in the previous cycle. When neither port or both ports were already there, a tie-break bit settles the choice and alternates between the two sides. The choice is kept until the contention ends. The next contention is then decided afresh.

A mode input selects master or slave operation. In master mode the block computes busy itself. In slave mode the busy flags come from an external master and are passed through unchanged. Several devices can then be stacked to widen the word while they all follow one arbitration result.

Top module: `busy_arb`

## Requirements
- R1: After reset the owner output reads 0 (no owner) and both busy flags are high. The first tie after reset goes to the left port.
- R2: When either enable is high or the two addresses differ, master mode keeps both busy flags high, and each gated write strobe equals its port's write strobe.
- R3: In master mode, if one port was enabled at the contended address in the previous cycle and the other port was not, the first port becomes owner. The other port's busy flag goes low in the same cycle the match appears.
- R4: In master mode, when both or neither port were already at the address, the winner alternates on successive ties: left, then right, then left.
- R5: While the contention lasts, the owner does not change, whatever the write strobes do.
- R6: Busy returns high in the same cycle that the addresses stop matching or either enable goes high. A later contention is decided afresh, by the R3 and R4 rules.
- R7: In slave mode (mode input low), each busy output equals its busy input. The owner reads 1 when only the right busy input is low, 2 when only the left busy input is low, and 0 otherwise. Address matches have no effect in slave mode.
- R8: In both modes, a port whose busy flag is low has its gated write strobe held high.
- R9: The owner output is encoded as 0 = none, 1 = left, 2 = right. At most one of its bits is set, and at most one busy flag is low in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1 selects master (busy computed here), 0 selects slave (busy imposed) |
| l_ce_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_addr | input | AW | Left port address |
| r_ce_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_addr | input | AW | Right port address |
| l_busy_in_n | input | 1 | Left busy from an external master, used in slave mode |
| r_busy_in_n | input | 1 | Right busy from an external master, used in slave mode |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_mem_we_n | output | 1 | Left write strobe after masking, to the array |
| r_mem_we_n | output | 1 | Right write strobe after masking, to the array |
| owner | output | 2 | Current owner: 0 none, 1 left, 2 right |

## Verification
The two functions that can fall in the same cycle are the decision on which port owns a location and the masking of a write strobe. The losing port's write can be issued in the very cycle its busy flag first drops. The bench provokes this by holding one port's write strobe low while moving its address onto the other port's address. In that same cycle it expects the gated strobe to be high and the busy flag low. Simultaneous arrivals are provoked by enabling both ports at one address from idle, and the bench judges them against the alternating tie order.

// File: rtl/busy_arb.sv
module busy_arb #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          l_ce_n,
  input  logic          l_we_n,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce_n,
  input  logic          r_we_n,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_mem_we_n,
  output logic          r_mem_we_n,
  output logic [1:0]    owner
);
  localparam logic [1:0] OWN_NONE = 2'd0;
  localparam logic [1:0] OWN_L    = 2'd1;
  localparam logic [1:0] OWN_R    = 2'd2;

  logic          l_prev_en, r_prev_en;
  logic [AW-1:0] l_prev_addr, r_prev_addr;
  logic [1:0]    owner_q, m_owner, s_owner;
  logic          tie_right_q;

  wire match  = !l_ce_n && !r_ce_n && (l_addr == r_addr);
  wire l_stay = l_prev_en && (l_prev_addr == l_addr);
  wire r_stay = r_prev_en && (r_prev_addr == r_addr);
  wire fresh  = match && (owner_q == OWN_NONE);
  wire tie    = (l_stay == r_stay);

  always_comb begin
    if (!match)                 m_owner = OWN_NONE;
    else if (owner_q != OWN_NONE) m_owner = owner_q;
    else if (tie)               m_owner = tie_right_q ? OWN_R : OWN_L;
    else                        m_owner = l_stay ? OWN_L : OWN_R;
  end

  always_comb begin
    if (!r_busy_in_n && l_busy_in_n)      s_owner = OWN_L;
    else if (!l_busy_in_n && r_busy_in_n) s_owner = OWN_R;
    else                                  s_owner = OWN_NONE;
  end

  assign owner      = master ? m_owner : s_owner;
  assign l_busy_n   = master ? (m_owner != OWN_R) : l_busy_in_n;
  assign r_busy_n   = master ? (m_owner != OWN_L) : r_busy_in_n;
  assign l_mem_we_n = l_we_n | ~l_busy_n;
  assign r_mem_we_n = r_we_n | ~r_busy_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_prev_en   <= 1'b0;
      r_prev_en   <= 1'b0;
      l_prev_addr <= '0;
      r_prev_addr <= '0;
      owner_q     <= OWN_NONE;
      tie_right_q <= 1'b0;
    end else begin
      l_prev_en   <= !l_ce_n;
      r_prev_en   <= !r_ce_n;
      l_prev_addr <= l_addr;
      r_prev_addr <= r_addr;
      owner_q     <= master ? m_owner : OWN_NONE;
      if (master && fresh && tie)
        tie_right_q <= !tie_right_q;
    end
  end
endmodule

// File: rtl/busy_arb_chk.sv
module busy_arb_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master,
  input logic          l_ce_n,
  input logic          l_we_n,
  input logic [AW-1:0] l_addr,
  input logic          r_ce_n,
  input logic          r_we_n,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in_n,
  input logic          r_busy_in_n,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_mem_we_n,
  input logic          r_mem_we_n,
  input logic [1:0]    owner
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  wire hit = !l_ce_n && !r_ce_n && (l_addr == r_addr);

  // R2
  idle_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !hit) |-> (l_busy_n && r_busy_n));
  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && master && hit && $past(master) && $past(hit)) |-> (owner == $past(owner)));
  // R7
  slave_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (l_busy_n == l_busy_in_n && r_busy_n == r_busy_in_n));
  // R8
  l_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> l_mem_we_n);
  // R8
  r_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> r_mem_we_n);
  // R9
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> (l_busy_n || r_busy_n));
  // R9
  owner_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));
  // R3
  contend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && hit) |-> (owner != 2'd0 && (l_busy_n != r_busy_n)));
endmodule

bind busy_arb busy_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master),
  .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
  .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
  .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_mem_we_n(l_mem_we_n), .r_mem_we_n(r_mem_we_n), .owner(owner)
);

// File: tb/test_busy_arb.sv
`timescale 1ns/1ps
module test_busy_arb;
  localparam int AW = 14;
  logic clk = 1'b0;
  logic rst_n, master, l_ce_n, l_we_n, r_ce_n, r_we_n, l_busy_in_n, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_n, r_busy_n, l_mem_we_n, r_mem_we_n;
  logic [1:0] owner;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  busy_arb #(.AW(AW)) i_busy_arb (
    .clk(clk), .rst_n(rst_n), .master(master),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_mem_we_n(l_mem_we_n), .r_mem_we_n(r_mem_we_n), .owner(owner)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic idle();
    l_ce_n = 1; r_ce_n = 1; l_we_n = 1; r_we_n = 1;
    nxt();
  endtask

  task automatic t_reset();
    look();
    chk("R1 owner", owner, 0);
    chk("R1 l_busy", l_busy_n, 1);
    chk("R1 r_busy", r_busy_n, 1);
  endtask

  task automatic t_tie();
    idle();
    l_ce_n = 0; r_ce_n = 0; l_addr = 7; r_addr = 7;
    look();
    chk("R1 first tie owner left", owner, 1);
    chk("R4 first tie r_busy", r_busy_n, 0);
    nxt();
    idle();
    l_ce_n = 0; r_ce_n = 0; l_addr = 9; r_addr = 9;
    look();
    chk("R4 second tie owner right", owner, 2);
    chk("R4 second tie l_busy", l_busy_n, 0);
    nxt();
    idle();
    l_ce_n = 0; r_ce_n = 0; l_addr = 2; r_addr = 2;
    look();
    chk("R4 third tie owner left", owner, 1);
    nxt();
    idle();
  endtask

  task automatic t_no_contend();
    l_ce_n = 0; r_ce_n = 0; l_addr = 10; r_addr = 11; l_we_n = 0; r_we_n = 0;
    look();
    chk("R2 diff addr l_busy", l_busy_n, 1);
    chk("R2 diff addr r_busy", r_busy_n, 1);
    chk("R2 l_mem_we", l_mem_we_n, 0);
    chk("R2 r_mem_we", r_mem_we_n, 0);
    nxt();
    r_ce_n = 1; r_addr = 10;
    look();
    chk("R2 one enable owner", owner, 0);
    chk("R2 one enable l_busy", l_busy_n, 1);
    nxt();
    idle();
  endtask

  task automatic t_left_first();
    l_ce_n = 0; l_addr = 5; r_ce_n = 1; r_addr = 5;
    nxt();
    r_ce_n = 0; r_we_n = 0; l_we_n = 0;
    look();
    chk("R3 left first owner", owner, 1);
    chk("R3 left first r_busy", r_busy_n, 0);
    chk("R8 loser write masked", r_mem_we_n, 1);
    chk("R8 winner write passes", l_mem_we_n, 0);
    for (int i = 0; i < 4; i++) begin
      nxt();
      l_we_n = i[0];
      look();
      chk("R5 owner held", owner, 1);
    end
    nxt();
    r_addr = 6;
    look();
    chk("R6 mismatch r_busy", r_busy_n, 1);
    chk("R6 mismatch r_mem_we", r_mem_we_n, 0);
    nxt();
    idle();
  endtask

  task automatic t_right_first();
    r_ce_n = 0; r_addr = 3; l_ce_n = 0; l_addr = 4;
    nxt();
    l_addr = 3; l_we_n = 0;
    look();
    chk("R3 right first owner", owner, 2);
    chk("R3 right first l_busy", l_busy_n, 0);
    chk("R8 left write masked", l_mem_we_n, 1);
    nxt();
    r_ce_n = 1;
    look();
    chk("R6 winner leaves l_busy", l_busy_n, 1);
    chk("R6 winner leaves owner", owner, 0);
    nxt();
    idle();
  endtask

  task automatic t_afresh();
    l_ce_n = 0; l_addr = 8; r_ce_n = 1; r_addr = 8;
    nxt();
    r_ce_n = 0;
    look();
    chk("R3 setup owner left", owner, 1);
    nxt();
    l_ce_n = 1;
    look();
    chk("R6 release owner", owner, 0);
    nxt();
    l_ce_n = 0;
    look();
    chk("R6 rearbitrated owner right", owner, 2);
    chk("R6 rearbitrated l_busy", l_busy_n, 0);
    nxt();
    idle();
  endtask

  task automatic t_slave();
    master = 0;
    l_ce_n = 0; r_ce_n = 0; l_addr = 12; r_addr = 12; l_we_n = 0; r_we_n = 0;
    l_busy_in_n = 1; r_busy_in_n = 1;
    nxt();
    look();
    chk("R7 match ignored l_busy", l_busy_n, 1);
    chk("R7 match ignored r_busy", r_busy_n, 1);
    chk("R7 owner none", owner, 0);
    nxt();
    r_busy_in_n = 0;
    look();
    chk("R7 imposed r_busy", r_busy_n, 0);
    chk("R7 owner left", owner, 1);
    chk("R8 slave r write masked", r_mem_we_n, 1);
    chk("R8 slave l write passes", l_mem_we_n, 0);
    nxt();
    r_busy_in_n = 1; l_busy_in_n = 0;
    look();
    chk("R7 imposed l_busy", l_busy_n, 0);
    chk("R7 owner right", owner, 2);
    chk("R8 slave l write masked", l_mem_we_n, 1);
    nxt();
    l_busy_in_n = 1; master = 1;
    idle();
  endtask

  initial begin
    rst_n = 0; master = 1; l_ce_n = 1; r_ce_n = 1; l_we_n = 1; r_we_n = 1;
    l_addr = 0; r_addr = 0; l_busy_in_n = 1; r_busy_in_n = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_tie();
    t_no_contend();
    t_left_first();
    t_right_first();
    t_afresh();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule